// File: doc/BRIEF.md
# DMA Service Scanner and Address Generator

This block chooses which of four DMA channels to serve and moves that channel's data one byte at a time over a simple request/acknowledge memory port. A register front end, not part of this block, supplies each channel's mask bit, request bit, starting address, byte count and mode. The block keeps each channel's progress and its terminal-count flag, and builds the full physical memory address from two page bytes and the channel's running 16-bit address.

The two page banks, low and high, are written and read through their own port. That port has an irregular 3-bit slot numbering. The high bank can be removed with a build parameter, which narrows the address the block produces. Verify-type channels count through their length without touching memory. A channel set to auto-reload restarts by itself after terminal count. Any other channel stops until software re-arms it.

Top module: `dma_service_engine`

## Requirements
- R1: After reset `mem_req` is 0, `tc_flag` is 0 and every page slot reads 0.
- R2: A channel can be granted only when its `ch_mask` bit is 0, its `ch_request` bit is 1 and it is not halted. Among the eligible channels, the lowest index is granted. Each new scan starts again from channel 0.
- R3: Page slot `pg_off` 7 belongs to channel 0, 3 to channel 1, 1 to channel 2 and 2 to channel 3. Writes to slots 0, 4, 5 and 6 change nothing, and those slots read 0. `pg_high`=1 selects the high bank.
- R4: `mem_addr` is {high page bits 6:0, low page byte, 16-bit current address}. Bit 7 of the high page byte plays no part.
- R5: For progress k, the current address is base+k when `cfg_down` is 0 and base−k when it is 1, both modulo 2^16.
- R6: `cfg_kind` 01 issues memory writes (`mem_we`=1) and 10 issues memory reads (`mem_we`=0). Kinds 00 and 11 advance one byte per cycle and never raise `mem_req`.
- R7: Each accepted `mem_ack` completes exactly one byte. While `mem_req` waits for `mem_ack`, both `mem_req` and `mem_addr` hold.
- R8: When a channel's progress reaches its count plus one, its `tc_flag` bit is set and the channel gives up the port.
- R9: At terminal count, an auto-reload channel resets its progress to 0 and stays eligible. Any other channel halts until it is re-armed. A `rearm` pulse clears that channel's progress, halt and flag, and it takes precedence over a terminal count in the same cycle.
- R10: While `ctrl_off` is 1, no channel is granted.
- R11: With `HI_PAGE_EN`=0, the top 7 address bits are 0 and high-bank slots read 0.
- R12: A granted channel keeps the port, even against a lower-index request, until terminal count or until its eligibility is gone at a byte boundary. Progress made before leaving is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_mask | input | 4 | Per-channel mask, 1 = blocked |
| ch_request | input | 4 | Per-channel service request |
| ctrl_off | input | 1 | Controller disable |
| cfg_base_addr | input | 64 | Four 16-bit starting addresses, channel 0 in the low bits |
| cfg_base_cnt | input | 64 | Four 16-bit counts (bytes minus one) |
| cfg_down | input | 4 | Per-channel decrement mode |
| cfg_autoreload | input | 4 | Per-channel auto-reload |
| cfg_kind | input | 8 | Four 2-bit transfer kinds |
| rearm | input | 4 | Per-channel re-arm pulse |
| pg_we | input | 1 | Page write strobe |
| pg_high | input | 1 | Page bank select, 1 = high |
| pg_off | input | 3 | Page slot |
| pg_wdata | input | 8 | Page write data |
| pg_rdata | output | 8 | Page read data (combinational) |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | 1 = write to memory |
| mem_addr | output | 31 | Physical byte address |
| mem_ack | input | 1 | Memory acknowledge |
| tc_flag | output | 4 | Terminal-count flags |

## Verification
Two events can fall on the same clock edge. The first is a terminal count and a request drop on one acknowledge: the bench drops the request in the very cycle it acknowledges a channel's last byte. It expects the flag to be set, and it expects no further request, even though an auto-reloaded channel would otherwise go on. The second is a terminal count and a re-arm on one acknowledge: the bench pulses re-arm together with the final acknowledge. It expects the flag to stay clear and the next request to carry the channel's starting address again. A second instance built without the high bank runs the same stimulus, and every address it produces is compared against the first instance's address.

// File: rtl/dma_svc_pkg.sv
package dma_svc_pkg;

    localparam int CH_COUNT = 4;
    localparam int CH_W     = $clog2(CH_COUNT);

    localparam logic [1:0] XT_VERIFY = 2'b00;
    localparam logic [1:0] XT_WRITE  = 2'b01;
    localparam logic [1:0] XT_READ   = 2'b10;

    typedef enum logic [0:0] {
        ST_SCAN = 1'b0,
        ST_XFER = 1'b1
    } svc_state_e;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] ch;
    } page_slot_t;

    // Irregular slot numbering of the page port; unlisted slots are holes.
    function automatic page_slot_t page_slot(input logic [2:0] off);
        page_slot_t s;
        s = '0;
        case (off)
            3'd7: s = '{hit: 1'b1, ch: CH_W'(0)};
            3'd3: s = '{hit: 1'b1, ch: CH_W'(1)};
            3'd1: s = '{hit: 1'b1, ch: CH_W'(2)};
            3'd2: s = '{hit: 1'b1, ch: CH_W'(3)};
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dma_chan_pick.sv
module dma_chan_pick #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  elig,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |elig;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dma_page_bank.sv
module dma_page_bank
    import dma_svc_pkg::*;
#(
    parameter int PW     = 8,
    parameter bit ENABLE = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [2:0]             off,
    input  logic [PW-1:0]          wdata,
    output logic [PW-1:0]          rdata,
    output logic [CH_COUNT*PW-1:0] pages
);
    generate
        if (ENABLE) begin : g_regs
            logic [CH_COUNT-1:0][PW-1:0] pg_d, pg_q;
            page_slot_t slot;

            always_comb begin
                slot = page_slot(off);
                pg_d = pg_q;
                if (wr_en && slot.hit) pg_d[slot.ch] = wdata;
                rdata = slot.hit ? pg_q[slot.ch] : '0;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) pg_q <= '0;
                else        pg_q <= pg_d;
            end

            assign pages = pg_q;

            // R3
            stray_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !slot.hit) |=> $stable(pg_q));
        end else begin : g_none
            logic unused_page_in;
            assign unused_page_in = ^{clk, rst_n, wr_en, off, wdata};
            assign rdata = '0;
            assign pages = '0;
        end
    endgenerate
endmodule

// File: rtl/dma_service_engine.sv
module dma_service_engine
    import dma_svc_pkg::*;
#(
    parameter int AW         = 16,
    parameter int PW         = 8,
    parameter int HPW        = 7,
    parameter bit HI_PAGE_EN = 1'b1,
    localparam int PGW       = AW + 1,
    localparam int MAW       = HPW + PW + AW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CH_COUNT-1:0]    ch_mask,
    input  logic [CH_COUNT-1:0]    ch_request,
    input  logic                   ctrl_off,
    input  logic [CH_COUNT*AW-1:0] cfg_base_addr,
    input  logic [CH_COUNT*AW-1:0] cfg_base_cnt,
    input  logic [CH_COUNT-1:0]    cfg_down,
    input  logic [CH_COUNT-1:0]    cfg_autoreload,
    input  logic [CH_COUNT*2-1:0]  cfg_kind,
    input  logic [CH_COUNT-1:0]    rearm,
    input  logic                   pg_we,
    input  logic                   pg_high,
    input  logic [2:0]             pg_off,
    input  logic [PW-1:0]          pg_wdata,
    output logic [PW-1:0]          pg_rdata,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [MAW-1:0]         mem_addr,
    input  logic                   mem_ack,
    output logic [CH_COUNT-1:0]    tc_flag
);
    typedef struct packed {
        svc_state_e                   st;
        logic [CH_W-1:0]              cur;
        logic [CH_COUNT-1:0][PGW-1:0] prog;
        logic [CH_COUNT-1:0]          halted;
        logic [CH_COUNT-1:0]          tc;
    } svc_regs_t;

    svc_regs_t r_d, r_q;

    // ---------------- page banks ----------------
    logic [CH_COUNT*PW-1:0] lo_flat, hi_flat;
    logic [PW-1:0]          lo_rd, hi_rd;

    dma_page_bank #(.PW(PW), .ENABLE(1'b1)) u_lo_page (
        .clk(clk), .rst_n(rst_n), .wr_en(pg_we && !pg_high), .off(pg_off),
        .wdata(pg_wdata), .rdata(lo_rd), .pages(lo_flat)
    );

    dma_page_bank #(.PW(PW), .ENABLE(HI_PAGE_EN)) u_hi_page (
        .clk(clk), .rst_n(rst_n), .wr_en(pg_we && pg_high), .off(pg_off),
        .wdata(pg_wdata), .rdata(hi_rd), .pages(hi_flat)
    );

    assign pg_rdata = pg_high ? hi_rd : lo_rd;

    logic unused_hi_bits;
    assign unused_hi_bits = ^hi_flat;

    // ---------------- channel pick ----------------
    logic [CH_COUNT-1:0] elig;
    logic                pick_any;
    logic [CH_W-1:0]     pick_idx;

    assign elig = ~ch_mask & ch_request & ~r_q.halted & {CH_COUNT{~ctrl_off}};

    dma_chan_pick #(.N(CH_COUNT), .IW(CH_W)) u_pick (
        .elig(elig), .any(pick_any), .idx(pick_idx)
    );

    // ---------------- current channel view ----------------
    logic [AW-1:0]  base_a, base_c, step, cur_addr;
    logic [1:0]     kind;
    logic           down, autold, needs_mem, in_xfer, byte_done;
    logic [PGW-1:0] prog_c, prog_nx, limit;

    always_comb begin
        base_a    = cfg_base_addr[r_q.cur*AW +: AW];
        base_c    = cfg_base_cnt[r_q.cur*AW +: AW];
        kind      = cfg_kind[r_q.cur*2 +: 2];
        down      = cfg_down[r_q.cur];
        autold    = cfg_autoreload[r_q.cur];
        prog_c    = r_q.prog[r_q.cur];
        step      = prog_c[AW-1:0];
        cur_addr  = down ? (base_a - step) : (base_a + step);
        needs_mem = (kind == XT_WRITE) || (kind == XT_READ);
        in_xfer   = (r_q.st == ST_XFER);
        byte_done = in_xfer && (!needs_mem || mem_ack);
        prog_nx   = prog_c + PGW'(1);
        limit     = {1'b0, base_c} + PGW'(1);
    end

    // ---------------- next state ----------------
    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_SCAN: begin
                if (pick_any) begin
                    r_d.st  = ST_XFER;
                    r_d.cur = pick_idx;
                end
            end
            ST_XFER: begin
                if (byte_done) begin
                    if (prog_nx == limit) begin
                        r_d.tc[r_q.cur]     = 1'b1;
                        r_d.prog[r_q.cur]   = autold ? '0 : prog_nx;
                        r_d.halted[r_q.cur] = !autold;
                        r_d.st              = ST_SCAN;
                    end else begin
                        r_d.prog[r_q.cur] = prog_nx;
                        if (!elig[r_q.cur]) r_d.st = ST_SCAN;
                    end
                end
            end
            default: r_d.st = ST_SCAN;
        endcase
        for (int i = 0; i < CH_COUNT; i++) begin
            if (rearm[i]) begin
                r_d.prog[i]   = '0;
                r_d.halted[i] = 1'b0;
                r_d.tc[i]     = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // ---------------- outputs ----------------
    assign mem_req  = in_xfer && needs_mem;
    assign mem_we   = (kind == XT_WRITE);
    assign mem_addr = {hi_flat[r_q.cur*PW +: HPW], lo_flat[r_q.cur*PW +: PW], cur_addr};
    assign tc_flag  = r_q.tc;

    // ---------------- assertions ----------------
    // R2
    grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SCAN && r_d.st == ST_XFER) |->
        (ch_request[r_d.cur] && !ch_mask[r_d.cur] && !ctrl_off));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && rearm == '0) |=> (mem_req && $stable(mem_addr)));

    // R8
    tc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(r_q.tc & ~$past(r_q.tc))) |-> ($past(r_q.st) == ST_XFER));

    // R10
    off_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SCAN && ctrl_off) |=> (r_q.st == ST_SCAN));

    // R12
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_XFER && $past(r_q.st) == ST_XFER) |-> (r_q.cur == $past(r_q.cur)));
endmodule

// File: tb/dma_service_engine_test.sv
module dma_service_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ch_mask = '0, ch_request = '0, cfg_down = '0, cfg_autoreload = '0, rearm = '0;
    logic        ctrl_off = 1'b0;
    logic [63:0] cfg_base_addr = '0, cfg_base_cnt = '0;
    logic [7:0]  cfg_kind = '0;
    logic        pg_we = 1'b0, pg_high = 1'b0, mem_ack = 1'b0;
    logic [2:0]  pg_off = '0;
    logic [7:0]  pg_wdata = '0, pg_rdata, pg_rdata_nh;
    logic        mem_req, mem_we, mem_req_nh, mem_we_nh;
    logic [30:0] mem_addr, mem_addr_nh;
    logic [3:0]  tc_flag, tc_flag_nh;

    always #10 clk = ~clk;

    dma_service_engine uut (
        .clk(clk), .rst_n(rst_n), .ch_mask(ch_mask), .ch_request(ch_request), .ctrl_off(ctrl_off),
        .cfg_base_addr(cfg_base_addr), .cfg_base_cnt(cfg_base_cnt), .cfg_down(cfg_down),
        .cfg_autoreload(cfg_autoreload), .cfg_kind(cfg_kind), .rearm(rearm),
        .pg_we(pg_we), .pg_high(pg_high), .pg_off(pg_off), .pg_wdata(pg_wdata), .pg_rdata(pg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack), .tc_flag(tc_flag));

    dma_service_engine #(.HI_PAGE_EN(1'b0)) uut_nohi (
        .clk(clk), .rst_n(rst_n), .ch_mask(ch_mask), .ch_request(ch_request), .ctrl_off(ctrl_off),
        .cfg_base_addr(cfg_base_addr), .cfg_base_cnt(cfg_base_cnt), .cfg_down(cfg_down),
        .cfg_autoreload(cfg_autoreload), .cfg_kind(cfg_kind), .rearm(rearm),
        .pg_we(pg_we), .pg_high(pg_high), .pg_off(pg_off), .pg_wdata(pg_wdata), .pg_rdata(pg_rdata_nh),
        .mem_req(mem_req_nh), .mem_we(mem_we_nh), .mem_addr(mem_addr_nh), .mem_ack(mem_ack),
        .tc_flag(tc_flag_nh));

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [7:0]  lo_m [4], hi_m [4];
    logic [15:0] b_base [4], b_cnt [4];
    logic        b_down [4], b_auto [4];
    logic [1:0]  b_kind [4];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int slot_ch(input logic [2:0] off);
        case (off)
            3'd1: return 2;
            3'd2: return 3;
            3'd3: return 1;
            3'd7: return 0;
            default: return -1;
        endcase
    endfunction

    function automatic logic [30:0] exp_addr(input int ch, input int k);
        logic [15:0] a;
        a = b_down[ch] ? (b_base[ch] - 16'(k)) : (b_base[ch] + 16'(k));
        return {hi_m[ch][6:0], lo_m[ch], a};
    endfunction

    task automatic set_chan(input int ch, input logic [15:0] base, input logic [15:0] cnt,
                            input logic dn, input logic au, input logic [1:0] kd);
        b_base[ch] = base; b_cnt[ch] = cnt; b_down[ch] = dn; b_auto[ch] = au; b_kind[ch] = kd;
        cfg_base_addr[ch*16 +: 16] = base;
        cfg_base_cnt[ch*16 +: 16]  = cnt;
        cfg_down[ch] = dn; cfg_autoreload[ch] = au; cfg_kind[ch*2 +: 2] = kd;
    endtask

    task automatic rearm_ch(input int ch);
        rearm[ch] = 1'b1;
        @(negedge clk);
        rearm = '0;
    endtask

    task automatic pg_write(input logic hi, input logic [2:0] off, input logic [7:0] v);
        pg_we = 1'b1; pg_high = hi; pg_off = off; pg_wdata = v;
        @(negedge clk);
        pg_we = 1'b0;
        if (slot_ch(off) >= 0) begin
            if (hi) hi_m[slot_ch(off)] = v;
            else    lo_m[slot_ch(off)] = v;
        end
    endtask

    // Waits for a request, checks it, and leaves mem_ack high at the current negedge.
    task automatic serve_byte(input int ch, input int k, input string tag);
        int t = 0;
        int d;
        logic [30:0] held;
        while (!mem_req && t < 40) begin @(negedge clk); t++; end
        check(mem_req, {tag, " R7 request seen"}, mem_req, 1);
        check(mem_addr == exp_addr(ch, k), {tag, " R4 R5 address"}, mem_addr, exp_addr(ch, k));
        check(mem_we == (b_kind[ch] == 2'b01), {tag, " R6 direction"}, mem_we, b_kind[ch] == 2'b01);
        check(mem_addr_nh == {7'b0, mem_addr[23:0]}, {tag, " R11 no-high address"}, mem_addr_nh,
              {7'b0, mem_addr[23:0]});
        held = mem_addr;
        d = $urandom % 3;
        for (int i = 0; i < d; i++) begin
            @(negedge clk);
            check(mem_req && mem_addr == held, {tag, " R7 hold until ack"}, mem_addr, held);
        end
        mem_ack = 1'b1;
    endtask

    task automatic ack_release();
        @(negedge clk);
        mem_ack = 1'b0;
        rearm = '0;
    endtask

    task automatic expect_idle(input int cyc, input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (mem_req) seen = 1'b1;
        end
        check(!seen, tag, seen, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4; i++) begin
            lo_m[i] = '0; hi_m[i] = '0;
            set_chan(i, 16'h0, 16'h0, 1'b0, 1'b0, 2'b01);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(!mem_req, "R1 mem_req after reset", mem_req, 0);
        check(tc_flag == 4'b0, "R1 tc_flag after reset", tc_flag, 0);
        pg_off = 3'd7; pg_high = 1'b0; #2;
        check(pg_rdata == 8'h0, "R1 low page after reset", pg_rdata, 0);
        pg_high = 1'b1; #2;
        check(pg_rdata == 8'h0, "R1 high page after reset", pg_rdata, 0);

        // R3 page map, including holes
        @(negedge clk);
        for (int o = 0; o < 8; o++) pg_write(1'b0, 3'(o), 8'h10 + 8'(o));
        for (int o = 0; o < 8; o++) pg_write(1'b1, 3'(o), 8'hA0 + 8'(o));
        for (int o = 0; o < 8; o++) begin
            for (int h = 0; h < 2; h++) begin
                logic [7:0] e;
                pg_high = h[0]; pg_off = 3'(o); #2;
                e = (slot_ch(3'(o)) < 0) ? 8'h0 : (h == 1 ? hi_m[slot_ch(3'(o))] : lo_m[slot_ch(3'(o))]);
                check(pg_rdata == e, "R3 page slot read", pg_rdata, e);
                check(pg_rdata_nh == (h == 1 ? 8'h0 : e), "R11 no-high page read", pg_rdata_nh,
                      h == 1 ? 8'h0 : e);
            end
        end
        @(negedge clk);

        // R2 priority with masked ch0, R5 up/down, R8 terminal count
        set_chan(1, 16'h1234, 16'd2, 1'b0, 1'b0, 2'b01);
        set_chan(3, 16'h0010, 16'd1, 1'b1, 1'b0, 2'b10);
        ch_mask = 4'b0001; ch_request = 4'b1011;
        for (int k = 0; k < 3; k++) begin serve_byte(1, k, "R2 ch1 first"); ack_release(); end
        check(tc_flag[1], "R8 tc ch1", tc_flag, 4'b0010);
        for (int k = 0; k < 2; k++) begin serve_byte(3, k, "R5 ch3 down"); ack_release(); end
        check(tc_flag == 4'b1010, "R8 tc ch1 and ch3", tc_flag, 4'b1010);
        expect_idle(8, "R9 halted channels and R2 masked channel stay idle");

        // R9 re-arm, R12 leave on request drop and keep progress
        rearm_ch(1);
        check(!tc_flag[1], "R9 rearm clears flag", tc_flag[1], 0);
        serve_byte(1, 0, "R9 rearmed ch1 restarts");
        ch_request = 4'b1001;
        ack_release();
        expect_idle(6, "R12 dropped request leaves port");
        ch_request = 4'b1011;
        serve_byte(1, 1, "R12 progress kept"); ack_release();
        serve_byte(1, 2, "R12 progress kept"); ack_release();
        check(tc_flag[1], "R8 tc ch1 again", tc_flag[1], 1);

        // R12 no preemption, R5 wrap, R9 auto-reload, tc with request drop
        set_chan(3, 16'hFFFE, 16'd3, 1'b0, 1'b0, 2'b01);
        set_chan(0, 16'h0100, 16'd1, 1'b0, 1'b1, 2'b10);
        ch_mask = 4'b0000; ch_request = 4'b1000;
        rearm_ch(3);
        serve_byte(3, 0, "R12 ch3 start");
        ch_request = 4'b1001;
        ack_release();
        serve_byte(3, 1, "R12 ch3 not preempted by ch0");
        ch_request = 4'b0001;
        ack_release();
        serve_byte(0, 0, "R2 rescan finds ch0"); ack_release();
        serve_byte(0, 1, "R2 rescan finds ch0"); ack_release();
        check(tc_flag[0], "R8 tc ch0", tc_flag[0], 1);
        serve_byte(0, 0, "R9 auto-reload restarts"); ack_release();
        serve_byte(0, 1, "R9 auto-reload second pass");
        ch_request = 4'b0000;
        ack_release();
        check(tc_flag[0], "R8 tc with same-cycle request drop", tc_flag[0], 1);
        expect_idle(6, "R12 idle after drop at terminal count");
        set_chan(3, 16'hFFFE, 16'd3, 1'b0, 1'b0, 2'b01);
        ch_request = 4'b1000;
        serve_byte(3, 2, "R5 address wrap"); ack_release();
        serve_byte(3, 3, "R5 address wrap"); ack_release();
        ch_request = 4'b0000;

        // R6 verify kind
        begin
            bit seen = 1'b0;
            int t = 0;
            set_chan(2, 16'h0500, 16'd3, 1'b0, 1'b0, 2'b00);
            ch_request = 4'b0100;
            while (!tc_flag[2] && t < 20) begin
                @(negedge clk); t++;
                if (mem_req) seen = 1'b1;
            end
            check(tc_flag[2], "R6 verify reaches terminal count", tc_flag[2], 1);
            check(!seen, "R6 verify issues no memory access", seen, 0);
            ch_request = 4'b0000;
        end

        // R10 controller disable
        ctrl_off = 1'b1;
        ch_request = 4'b0100;
        rearm_ch(2);
        repeat (12) @(negedge clk);
        check(!tc_flag[2], "R10 nothing starts while disabled", tc_flag[2], 0);
        ctrl_off = 1'b0;
        begin
            int t = 0;
            while (!tc_flag[2] && t < 20) begin @(negedge clk); t++; end
            check(tc_flag[2], "R10 resumes after enable", tc_flag[2], 1);
        end
        ch_request = 4'b0000;

        // R9 rearm in the same cycle as the terminal byte
        set_chan(1, 16'h0400, 16'd1, 1'b0, 1'b0, 2'b01);
        rearm_ch(1);
        ch_request = 4'b0010;
        serve_byte(1, 0, "R9 collision setup"); ack_release();
        serve_byte(1, 1, "R9 collision final byte");
        rearm = 4'b0010;
        ack_release();
        check(!tc_flag[1], "R9 rearm wins over terminal count", tc_flag[1], 0);
        serve_byte(1, 0, "R9 restarts from base after collision");
        ch_request = 4'b0000;
        ack_release();

        // Random single-channel runs
        for (int it = 0; it < 24; it++) begin
            int ch, cnt;
            ch  = $urandom % 4;
            cnt = $urandom % 5;
            set_chan(ch, 16'($urandom), 16'(cnt), 1'($urandom), 1'b0, ($urandom % 2) ? 2'b01 : 2'b10);
            rearm_ch(ch);
            ch_request = 4'b0001 << ch;
            for (int k = 0; k <= cnt; k++) begin
                serve_byte(ch, k, "R5 random run");
                if (k == cnt) ch_request = 4'b0000;
                ack_release();
            end
            check(tc_flag[ch], "R8 random run terminal count", tc_flag, 4'b0001 << ch);
        end

        done = 1'b1;
        summary();
    end
endmodule